// File: doc/BRIEF.md
# Single-Slope PWM Timer with Selectable Period

This block is a 16-bit up-counter that produces a sawtooth and two pulse-width-modulated outputs. The counter advances only on cycles where the timer-clock enable is high. When it equals the selected period limit (TOP), the next enabled cycle clears it to zero. TOP comes from a 3-bit period mode. The mode picks one of three fixed limits, an unbuffered period register, or the active value of compare channel A.

Each of the two compare channels holds a written value in a buffer. The value becomes active only at the end of a period, so a duty-cycle change never tears a running period. When the counter equals a channel's active value, the channel sets its sticky match flag. The same event ends the high phase of that channel's waveform. Each output can be driven non-inverted, inverted or held low.

Four sticky flags report period end, the two compare matches and the period-register match. Software clears a flag by pulsing a 1 on its bit of the clear input. Writes arrive through one data bus with one write strobe per register.

Top module: `fpwm_timer`

## Requirements
- R1: After reset the count, all four flags, both compare buffers, both active compare values, the period register and both waveform registers are zero.
- R2: On each cycle with `tick` high the count rises by one, unless it equals TOP, in which case it becomes zero. With `tick` low the count holds.
- R3: `period_mode` selects TOP: 0 gives 0x00FF, 1 gives 0x01FF, 2 gives 0x03FF, 3 gives the period register, 4 gives the active compare A value, and 5 to 7 give 0xFFFF.
- R4: Flag bit 0 (period end) is set on the enabled cycle where the count equals TOP. In that same cycle, period mode 3 also sets flag bit 3 (period-register match) and period mode 4 also sets flag bit 1 (compare A).
- R5: A write to compare A or compare B only loads its buffer. The active value takes the buffer contents on the enabled cycle where the count equals TOP.
- R6: A write to the period register takes effect at once. If the new value is below the running count, the counter continues through 0xFFFF, wraps to 0x0000 without a period-end flag, and ends the period at the next match.
- R7: In period modes 0 to 2, a compare write stores only the bits below the selected resolution (8, 9 or 10 bits) and forces the rest to zero.
- R8: Flag bit 1 (channel A) or bit 2 (channel B) is set on an enabled cycle where the count equals that channel's active value. An active value above TOP never sets it.
- R9: The waveform register of a channel is set on the period-end cycle and cleared on its compare-match cycle, with the set winning when both occur. Output mode 2 drives the waveform register unchanged.
- R10: Output mode 3 drives the complement of the waveform register, and output modes 0 and 1 drive the pin low.
- R11: Flags are sticky. A 1 on a bit of `flag_clr` clears that flag, unless the same flag is being set in that cycle, in which case it stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Timer-clock enable; the counter moves only when high |
| period_mode | input | 3 | TOP source select (see R3) |
| wr_data | input | 16 | Write data for all registers |
| wr_cmp_a | input | 1 | Write strobe for the compare A buffer |
| wr_cmp_b | input | 1 | Write strobe for the compare B buffer |
| wr_period | input | 1 | Write strobe for the period register |
| out_mode_a | input | 2 | Output mode of channel A |
| out_mode_b | input | 2 | Output mode of channel B |
| flag_clr | input | 4 | Write-one-to-clear for the flags |
| count | output | 16 | Current counter value |
| pwm_a | output | 1 | Channel A waveform |
| pwm_b | output | 1 | Channel B waveform |
| flags | output | 4 | Sticky flags: bit 0 period end, bit 1 compare A, bit 2 compare B, bit 3 period-register match |

## Verification
The assertions check, on every cycle, the properties that hold locally:
- the count advances or holds according to `tick`, and clears after TOP;
- the period-end and source flags rise at TOP;
- active compare values move only at a period end;
- compare matches raise their flags;
- flags stay set until cleared;
- a non-inverted output goes high at the period end.

Some behaviours span many cycles or depend on history, and only the bench's scenarios can show them:
- the missed-TOP run through 0xFFFF after the period register is lowered;
- the masking of compare writes in the fixed modes;
- the one-period delay before a buffered compare value takes effect;
- a compare value above TOP never producing a match.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;

  // period mode codes
  localparam logic [2:0] PM_FIX8   = 3'd0;
  localparam logic [2:0] PM_FIX9   = 3'd1;
  localparam logic [2:0] PM_FIX10  = 3'd2;
  localparam logic [2:0] PM_PERREG = 3'd3;
  localparam logic [2:0] PM_CMPA   = 3'd4;

  // output mode codes
  localparam logic [1:0] OM_NORMAL = 2'd2;
  localparam logic [1:0] OM_INVERT = 2'd3;

  // flag bit positions
  localparam int FLG_END  = 0;
  localparam int FLG_CMPA = 1;
  localparam int FLG_CMPB = 2;
  localparam int FLG_PER  = 3;
  localparam int NUM_FLAGS = 4;

  localparam int NUM_CH = 2;

endpackage

// File: rtl/fpwm_top_sel.sv
module fpwm_top_sel
  import fpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [2:0]       period_mode,
  input  logic [CNT_W-1:0] period_reg,
  input  logic [CNT_W-1:0] cmp_a_active,
  output logic [CNT_W-1:0] top_val,
  output logic [CNT_W-1:0] wr_mask
);

  localparam logic [CNT_W-1:0] ALL1   = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LIM8   = ALL1 >> (CNT_W - 8);
  localparam logic [CNT_W-1:0] LIM9   = ALL1 >> (CNT_W - 9);
  localparam logic [CNT_W-1:0] LIM10  = ALL1 >> (CNT_W - 10);

  always_comb begin
    top_val = ALL1;
    wr_mask = ALL1;
    case (period_mode)
      PM_FIX8:   begin top_val = LIM8;  wr_mask = LIM8;  end
      PM_FIX9:   begin top_val = LIM9;  wr_mask = LIM9;  end
      PM_FIX10:  begin top_val = LIM10; wr_mask = LIM10; end
      PM_PERREG: top_val = period_reg;
      PM_CMPA:   top_val = cmp_a_active;
      default:   top_val = ALL1;
    endcase
  end

endmodule

// File: rtl/fpwm_counter.sv
module fpwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] top_val,
  output logic [CNT_W-1:0] count,
  output logic             roll
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             at_top;

  always_comb begin
    at_top = (cnt_q == top_val);
    roll   = tick && at_top;
    cnt_d  = cnt_q;
    if (tick) begin
      if (at_top) cnt_d = '0;
      else        cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

endmodule

// File: rtl/fpwm_chan.sv
module fpwm_chan
  import fpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             roll,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_val,
  input  logic [CNT_W-1:0] count,
  input  logic [1:0]       out_mode,
  output logic [CNT_W-1:0] active,
  output logic             match,
  output logic             pwm
);

  logic [CNT_W-1:0] buf_q, buf_d;
  logic [CNT_W-1:0] act_q, act_d;
  logic             wave_q, wave_d;

  always_comb begin
    buf_d  = wr_en ? wr_val : buf_q;
    act_d  = roll ? buf_q : act_q;
    match  = tick && (count == act_q);
    wave_d = wave_q;
    if (roll)       wave_d = 1'b1;
    else if (match) wave_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      act_q  <= '0;
      wave_q <= 1'b0;
    end else begin
      buf_q  <= buf_d;
      act_q  <= act_d;
      wave_q <= wave_d;
    end
  end

  always_comb begin
    case (out_mode)
      OM_NORMAL: pwm = wave_q;
      OM_INVERT: pwm = ~wave_q;
      default:   pwm = 1'b0;
    endcase
  end

  assign active = act_q;

endmodule

// File: rtl/fpwm_timer.sv
module fpwm_timer
  import fpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [2:0]       period_mode,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             wr_cmp_a,
  input  logic             wr_cmp_b,
  input  logic             wr_period,
  input  logic [1:0]       out_mode_a,
  input  logic [1:0]       out_mode_b,
  input  logic [3:0]       flag_clr,
  output logic [CNT_W-1:0] count,
  output logic             pwm_a,
  output logic             pwm_b,
  output logic [3:0]       flags
);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  // period register, unbuffered
  logic [CNT_W-1:0] per_q, per_d;
  always_comb per_d = wr_period ? wr_data : per_q;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) per_q <= '0;
    else          per_q <= per_d;
  end

  logic [CNT_W-1:0]             top_val;
  logic [CNT_W-1:0]             wr_mask;
  logic [NUM_CH-1:0][CNT_W-1:0] act_val;
  logic [NUM_CH-1:0]            ch_match;
  logic [NUM_CH-1:0]            ch_pwm;
  logic [NUM_CH-1:0]            ch_wr;
  logic [NUM_CH-1:0][1:0]       ch_mode;
  logic                         roll;
  logic [CNT_W-1:0]             masked_data;

  assign ch_wr       = {wr_cmp_b, wr_cmp_a};
  assign ch_mode     = {out_mode_b, out_mode_a};
  assign masked_data = wr_data & wr_mask;

  fpwm_top_sel #(.CNT_W(CNT_W)) u_top_sel (
    .period_mode  (period_mode),
    .period_reg   (per_q),
    .cmp_a_active (act_val[0]),
    .top_val      (top_val),
    .wr_mask      (wr_mask)
  );

  fpwm_counter #(.CNT_W(CNT_W)) u_counter (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .tick    (tick),
    .top_val (top_val),
    .count   (count),
    .roll    (roll)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    fpwm_chan #(.CNT_W(CNT_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_q_n),
      .tick     (tick),
      .roll     (roll),
      .wr_en    (ch_wr[g]),
      .wr_val   (masked_data),
      .count    (count),
      .out_mode (ch_mode[g]),
      .active   (act_val[g]),
      .match    (ch_match[g]),
      .pwm      (ch_pwm[g])
    );
  end

  assign pwm_a = ch_pwm[0];
  assign pwm_b = ch_pwm[1];

  // sticky flags, set wins over clear
  logic [NUM_FLAGS-1:0] flg_q, flg_d, flg_set;

  always_comb begin
    flg_set           = '0;
    flg_set[FLG_END]  = roll;
    flg_set[FLG_CMPA] = ch_match[0] || (roll && period_mode == PM_CMPA);
    flg_set[FLG_CMPB] = ch_match[1];
    flg_set[FLG_PER]  = roll && (period_mode == PM_PERREG);
    flg_d             = (flg_q & ~flag_clr) | flg_set;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) flg_q <= '0;
    else          flg_q <= flg_d;
  end

  assign flags = flg_q;

endmodule

// File: rtl/fpwm_timer_chk.sv
module fpwm_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [2:0]       period_mode,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] top_val,
  input logic [CNT_W-1:0] act_a,
  input logic [CNT_W-1:0] act_b,
  input logic [3:0]       flags,
  input logic [3:0]       flag_clr,
  input logic [1:0]       out_mode_a,
  input logic             pwm_a
);

  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count != top_val) |=> count == CNT_W'($past(count) + 1'b1));

  assert_top_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count == top_val) |=> count == '0);

  assert_end_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count == top_val) |=> flags[0]);

  assert_per_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count == top_val && period_mode == 3'd3) |=> flags[3]);

  assert_cmpa_top_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count == top_val && period_mode == 3'd4) |=> flags[1]);

  assert_act_a_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && count == top_val) |=> $stable(act_a));

  assert_act_b_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && count == top_val) |=> $stable(act_b));

  assert_cmpb_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count == act_b) |=> flags[2]);

  assert_pwm_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count == top_val && out_mode_a == 2'd2) |=> (out_mode_a != 2'd2) || pwm_a);

  assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && !flag_clr[0]) |=> flags[0]);

endmodule

bind fpwm_timer fpwm_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_q_n),
  .tick        (tick),
  .period_mode (period_mode),
  .count       (count),
  .top_val     (top_val),
  .act_a       (act_val[0]),
  .act_b       (act_val[1]),
  .flags       (flags),
  .flag_clr    (flag_clr),
  .out_mode_a  (out_mode_a),
  .pwm_a       (pwm_a)
);

// File: tb/fpwm_timer_test.sv
`timescale 1ns/1ps
module fpwm_timer_test;

  logic        clk;
  logic        rst_n;
  logic        tick;
  logic [2:0]  period_mode;
  logic [15:0] wr_data;
  logic        wr_cmp_a, wr_cmp_b, wr_period;
  logic [1:0]  out_mode_a, out_mode_b;
  logic [3:0]  flag_clr;
  logic [15:0] count;
  logic        pwm_a, pwm_b;
  logic [3:0]  flags;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  fpwm_timer uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .period_mode(period_mode),
    .wr_data(wr_data), .wr_cmp_a(wr_cmp_a), .wr_cmp_b(wr_cmp_b),
    .wr_period(wr_period), .out_mode_a(out_mode_a), .out_mode_b(out_mode_b),
    .flag_clr(flag_clr), .count(count), .pwm_a(pwm_a), .pwm_b(pwm_b),
    .flags(flags)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_to(input logic [15:0] v);
    for (int i = 0; i < 70000 && count !== v; i++) step(1);
  endtask

  task automatic do_reset(input logic [2:0] m);
    rst_n = 1'b0; tick = 1'b0; period_mode = m; wr_data = '0;
    wr_cmp_a = 0; wr_cmp_b = 0; wr_period = 0; flag_clr = '0;
    out_mode_a = 2'd2; out_mode_b = 2'd2;
    step(3);
    rst_n = 1'b1;
    step(3);
  endtask

  task automatic write(input int which, input logic [15:0] d);
    wr_data = d;
    wr_cmp_a = (which == 0); wr_cmp_b = (which == 1); wr_period = (which == 2);
    step(1);
    wr_cmp_a = 0; wr_cmp_b = 0; wr_period = 0;
  endtask

  task automatic clear_flags();
    flag_clr = 4'hF; step(1); flag_clr = 4'h0;
  endtask

  task automatic t_reset();
    do_reset(3'd0);
    check("R1 count", count, 0);
    check("R1 flags", flags, 0);
    check("R1 pwm", {pwm_a, pwm_b}, 0);
  endtask

  task automatic t_fixed_periods();
    do_reset(3'd0);
    tick = 1;
    step(255);
    check("R2 R3 count reaches 0xFF", count, 16'h00FF);
    check("R4 no end flag before TOP tick", flags[0], 0);
    step(1);
    check("R2 clear after TOP", count, 0);
    check("R4 end flag", flags[0], 1);
    step(1);
    check("R2 restart", count, 1);
    tick = 0; step(5);
    check("R2 hold when tick low", count, 1);

    do_reset(3'd1); tick = 1;
    step(511);
    check("R3 9-bit TOP", count, 16'h01FF);
    step(1);
    check("R3 9-bit wrap", count, 0);

    do_reset(3'd2); tick = 1;
    step(1023);
    check("R3 10-bit TOP", count, 16'h03FF);
    step(1);
    check("R3 10-bit wrap", count, 0);
  endtask

  task automatic t_buffer_and_output();
    do_reset(3'd0); tick = 1;
    write(0, 16'h0040);
    clear_flags();
    run_to(16'h0050);
    check("R5 buffered A not active yet", flags[1], 0);
    run_to(16'h00FF);
    step(1);
    clear_flags();
    run_to(16'h0040);
    check("R8 no A match before 0x40 tick", flags[1], 0);
    check("R9 output high after period end", pwm_a, 1);
    step(1);
    check("R5 R8 A match after load", flags[1], 1);
    check("R9 output cleared at match", pwm_a, 0);
    out_mode_a = 2'd3; #1;
    check("R10 inverted", pwm_a, 1);
    out_mode_a = 2'd0; #1;
    check("R10 mode 0 low", pwm_a, 0);
    out_mode_a = 2'd1; #1;
    check("R10 mode 1 low", pwm_a, 0);
    out_mode_a = 2'd2;
  endtask

  task automatic t_mask();
    do_reset(3'd0); tick = 1;
    write(1, 16'h1234);
    run_to(16'h00FF);
    step(1);
    clear_flags();
    run_to(16'h0034);
    check("R7 no B match before 0x34", flags[2], 0);
    step(1);
    check("R7 masked B matches at 0x34", flags[2], 1);
  endtask

  task automatic t_period_reg();
    do_reset(3'd3);
    write(2, 16'h0020);
    tick = 1;
    step(32);
    check("R3 period register TOP", count, 16'h0020);
    check("R4 no end flag yet", {flags[3], flags[0]}, 0);
    step(1);
    check("R2 wrap at period register", count, 0);
    check("R4 end and period flags", {flags[3], flags[0]}, 2'b11);
    run_to(16'h0010);
    flag_clr = 4'hF;
    write(2, 16'h0008);
    flag_clr = 4'h0;
    run_to(16'h0030);
    check("R6 TOP missed", flags[0], 0);
    run_to(16'h0000);
    check("R6 no end flag at 0xFFFF wrap", flags[0], 0);
    step(8);
    check("R6 count at new TOP", count, 16'h0008);
    step(1);
    check("R6 period ends after wrap", {flags[3], flags[0], count}, {1'b1, 1'b1, 16'h0000});
  endtask

  task automatic t_cmpa_top();
    do_reset(3'd4);
    write(0, 16'h0030);
    write(1, 16'h0040);
    tick = 1;
    step(1);
    check("R4 first period end at TOP 0", flags[0], 1);
    clear_flags();
    check("R11 clear", flags, 0);
    run_to(16'h0030);
    check("R8 no flags inside period", flags, 0);
    step(1);
    check("R3 R4 compare A as TOP", {count, flags}, {16'h0000, 4'b0011});
    run_to(16'h0030);
    step(1);
    check("R8 B above TOP never matches", flags[2], 0);
  endtask

  task automatic t_flag_priority();
    do_reset(3'd0); tick = 1;
    run_to(16'h00FF);
    flag_clr = 4'h1; step(1); flag_clr = 4'h0;
    check("R11 set wins over clear", flags[0], 1);
    step(3);
    check("R11 sticky", flags[0], 1);
    flag_clr = 4'h1; step(1); flag_clr = 4'h0;
    check("R11 write-one clears", flags[0], 0);
  endtask

  initial begin
    t_reset();
    t_fixed_periods();
    t_buffer_and_output();
    t_mask();
    t_period_reg();
    t_cmpa_top();
    t_flag_priority();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule